// File: doc/BRIEF.md
# Reference Rate Detector and Monitor

This block watches one reference clock input using a fast local sampling clock. It decides which of four nominal telecom rates the reference carries (8 kHz, 2.048 MHz, 8.192 MHz or 19.44 MHz) and reports that rate to downstream timing logic. It also raises a failure flag when the reference stops behaving like the rate it was qualified at. The input passes through a two-flop synchronizer and a rising-edge detector. Every reference period is then measured as a count of sampling-clock cycles.

Two independent checkers guard a qualified reference, and the failure flag is their OR. The single-cycle checker tests each period against a window that belongs to the detected rate, and it times out when edges stop arriving. The coarse checker counts reference edges over a window of about 30 µs and compares the total with bounds derived from the detected rate. After a failure the rate is found again only once enough consecutive periods agree.

All window limits follow from the parameter `SAMPLE_MHZ`. A period of P sampling cycles means P cycles between two successive detected rising edges.

Top module: `ref_rate_monitor`

## Requirements
- R1: `rate_code` uses this encoding: 0 = 8 kHz, 1 = 2.048 MHz, 2 = 8.192 MHz, 3 = 19.44 MHz. Each measured period is classified as follows:
  - 8 kHz if it is at least 25 µs;
  - 2.048 MHz if it is at least 300 ns;
  - 8.192 MHz if it is at least 85 ns;
  - 19.44 MHz otherwise.
- R2: While not valid, `rate_valid` rises, and `rate_code` takes the new class, on the cycle after the edge that completes 4 consecutive periods. Those periods must share one class and each must lie inside that class's window. The first edge after reset or after a failure only starts a measurement.
- R3: While valid, an edge whose period falls outside the window of the held rate drops `rate_valid` and raises `ref_fail` on the next cycle. The windows in sampling cycles are floor(lo·f) to ceil(hi·f)+1, with f the sampling rate and lo/hi as follows:
  - 8 kHz: 121–128 µs;
  - 2.048 MHz: 263–712 ns;
  - 8.192 MHz: 63–175 ns;
  - 19.44 MHz: 38–75 ns.
- R4: While valid, if no edge arrives within the upper window limit of the held rate, the failure is flagged without waiting for a further edge.
- R5: While valid, edges are counted over back-to-back windows of 30 µs that start on the cycle after lock. The failure is flagged if a window's total falls outside the bounds for the held rate. The bounds are the expected count ±10 %, widened by one count each way.
- R6: `ref_fail` is never high together with `rate_valid`. Once set, it stays high until the next lock, and it clears on the same cycle that `rate_valid` rises.
- R7: `rate_code` changes only on the cycle that `rate_valid` rises. After a failure it keeps the last qualified rate.
- R8: Periods outside the window of their own class never count toward lock.
- R9: During and right after reset (`rst_n` low, synchronous), `rate_valid`, `ref_fail` and `rate_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference clock |
| rate_code | output | 2 | Detected rate (R1 encoding) |
| rate_valid | output | 1 | Reference qualified at `rate_code` |
| ref_fail | output | 1 | Sticky failure of a qualified reference |

## Verification
The assertions assume that every high and low phase of `ref_in` lasts at least one sampling cycle. Under that assumption each reference edge produces exactly one detected edge, and the gap counter in the checker tracks the measured period. The bench meets this by driving the reference on the falling edge of the sampling clock, with whole-cycle high and low phases of at least one cycle. Its periods are chosen so that each one lies clearly inside or clearly outside a window, or a coarse bound, for every rate it exercises.

// File: rtl/refmon_pkg.sv
// Shared types and limit arithmetic for the reference rate monitor.
// Assumes the sampling clock is given in MHz and all windows in ns.
package refmon_pkg;

    typedef enum logic [1:0] {
        RATE_8K    = 2'd0,
        RATE_2M048 = 2'd1,
        RATE_8M192 = 2'd2,
        RATE_19M44 = 2'd3
    } rate_e;

    localparam int NUM_RATES = 4;

    // Lower period limit in ns per rate
    function automatic int win_lo_ns(input int r);
        case (r)
            0:       return 121000;
            1:       return 263;
            2:       return 63;
            default: return 38;
        endcase
    endfunction

    // Upper period limit in ns per rate
    function automatic int win_hi_ns(input int r);
        case (r)
            0:       return 128000;
            1:       return 712;
            2:       return 175;
            default: return 75;
        endcase
    endfunction

    // Nominal rate in kHz
    function automatic int rate_khz(input int r);
        case (r)
            0:       return 8;
            1:       return 2048;
            2:       return 8192;
            default: return 19440;
        endcase
    endfunction

    // Lowest period (ns) that classifies as rate r; rate 3 takes the rest
    function automatic int cls_ns(input int r);
        case (r)
            0:       return 25000;
            1:       return 300;
            default: return 85;
        endcase
    endfunction

    function automatic int cls_ticks(input int r, input int mhz);
        return cls_ns(r) * mhz / 1000;
    endfunction

    function automatic int per_min_ticks(input int r, input int mhz);
        return win_lo_ns(r) * mhz / 1000;
    endfunction

    // Ceiling of the upper limit plus one for sampling quantization
    function automatic int per_max_ticks(input int r, input int mhz);
        return (win_hi_ns(r) * mhz + 999) / 1000 + 1;
    endfunction

    // Expected edges per window in thousandths
    function automatic int exp_milli(input int r, input int win, input int mhz);
        return win * rate_khz(r) / mhz;
    endfunction

    function automatic int cnt_lo(input int r, input int win, input int mhz, input int tol);
        int v;
        v = exp_milli(r, win, mhz) * (100 - tol) / 100000 - 1;
        return (v < 0) ? 0 : v;
    endfunction

    function automatic int cnt_hi(input int r, input int win, input int mhz, input int tol);
        return (exp_milli(r, win, mhz) * (100 + tol) + 99999) / 100000 + 1;
    endfunction

endpackage

// File: rtl/refmon_sync.sv
// Two-flop synchronizer plus rising-edge detector for the reference.
// Assumes each reference phase lasts at least one sampling cycle.
module refmon_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    logic s1, s2, s3;

    // Synchronize and keep one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ref_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_o = s2 & ~s3;
endmodule

// File: rtl/refmon_period.sv
// Measures cycles since the previous edge and classifies that period.
// The counter saturates; a saturated value fits no window.
module refmon_period
    import refmon_pkg::*;
#(
    parameter int SAMPLE_MHZ = 200,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    output logic [CNT_W-1:0] since_o,
    output rate_e            cand_o,
    output logic             cand_ok_o
);
    localparam logic [CNT_W-1:0] SAT    = '1;
    localparam logic [CNT_W-1:0] CLS_8K = CNT_W'(cls_ticks(0, SAMPLE_MHZ));
    localparam logic [CNT_W-1:0] CLS_2M = CNT_W'(cls_ticks(1, SAMPLE_MHZ));
    localparam logic [CNT_W-1:0] CLS_8M = CNT_W'(cls_ticks(2, SAMPLE_MHZ));

    logic [NUM_RATES-1:0] fit;

    // Cycles since last edge; holds the period on an edge cycle
    always_ff @(posedge clk) begin
        if (!rst_n)            since_o <= SAT;
        else if (edge_i)       since_o <= CNT_W'(1);
        else if (since_o != SAT) since_o <= since_o + CNT_W'(1);
    end

    // Class by period thresholds, slowest rate first
    always_comb begin
        if (since_o >= CLS_8K)      cand_o = RATE_8K;
        else if (since_o >= CLS_2M) cand_o = RATE_2M048;
        else if (since_o >= CLS_8M) cand_o = RATE_8M192;
        else                        cand_o = RATE_19M44;
    end

    // One window comparator per rate
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_fit
        localparam logic [CNT_W-1:0] LO = CNT_W'(per_min_ticks(g, SAMPLE_MHZ));
        localparam logic [CNT_W-1:0] HI = CNT_W'(per_max_ticks(g, SAMPLE_MHZ));
        assign fit[g] = (since_o >= LO) && (since_o <= HI);
    end

    assign cand_ok_o = fit[cand_o];
endmodule

// File: rtl/refmon_cycle_check.sv
// Single-cycle checker: period window test on each edge, timeout between.
// Combinational; the acquisition block registers its verdict.
module refmon_cycle_check
    import refmon_pkg::*;
#(
    parameter int SAMPLE_MHZ = 200,
    parameter int CNT_W      = 16
) (
    input  logic             active_i,
    input  logic             edge_i,
    input  logic [CNT_W-1:0] since_i,
    input  rate_e            rate_i,
    output logic             fault_o
);
    logic [CNT_W-1:0] lo_tab [NUM_RATES];
    logic [CNT_W-1:0] hi_tab [NUM_RATES];
    logic [CNT_W-1:0] lo, hi;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
        assign lo_tab[g] = CNT_W'(per_min_ticks(g, SAMPLE_MHZ));
        assign hi_tab[g] = CNT_W'(per_max_ticks(g, SAMPLE_MHZ));
    end

    assign lo = lo_tab[rate_i];
    assign hi = hi_tab[rate_i];

    // Window test on an edge, missing-edge timeout otherwise
    always_comb begin
        if (!active_i)    fault_o = 1'b0;
        else if (edge_i)  fault_o = (since_i < lo) || (since_i > hi);
        else              fault_o = (since_i > hi);
    end
endmodule

// File: rtl/refmon_freq_check.sv
// Coarse frequency checker: counts edges over fixed windows while
// active and flags a count outside the bounds of the held rate.
module refmon_freq_check
    import refmon_pkg::*;
#(
    parameter int SAMPLE_MHZ = 200,
    parameter int WIN_TICKS  = 6000,
    parameter int TOL_PCT    = 10
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active_i,
    input  logic  edge_i,
    input  rate_e rate_i,
    output logic  fault_o
);
    localparam int WIN_W  = $clog2(WIN_TICKS);
    localparam int ECNT_W = $clog2(WIN_TICKS + 2);

    logic [WIN_W-1:0]  win_cnt;
    logic [ECNT_W-1:0] edge_cnt;
    logic [ECNT_W-1:0] total;
    logic [ECNT_W-1:0] lo_tab [NUM_RATES];
    logic [ECNT_W-1:0] hi_tab [NUM_RATES];
    logic              win_end;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_bnd
        assign lo_tab[g] = ECNT_W'(cnt_lo(g, WIN_TICKS, SAMPLE_MHZ, TOL_PCT));
        assign hi_tab[g] = ECNT_W'(cnt_hi(g, WIN_TICKS, SAMPLE_MHZ, TOL_PCT));
    end

    assign win_end = (win_cnt == WIN_W'(WIN_TICKS - 1));
    assign total   = edge_cnt + ECNT_W'(edge_i);

    // Window position and edge tally, cleared while inactive
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i || win_end) begin
            win_cnt  <= '0;
            edge_cnt <= '0;
        end else begin
            win_cnt  <= win_cnt + WIN_W'(1);
            edge_cnt <= total;
        end
    end

    // Bound test on the last cycle of each window
    assign fault_o = active_i && win_end &&
                     ((total < lo_tab[rate_i]) || (total > hi_tab[rate_i]));
endmodule

// File: rtl/refmon_acq.sv
// Acquisition and lock control: qualifies a rate after ACQ_N agreeing
// in-window periods, drops lock and sets the sticky failure on a fault.
module refmon_acq
    import refmon_pkg::*;
#(
    parameter int ACQ_N = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  edge_i,
    input  rate_e cand_i,
    input  logic  cand_ok_i,
    input  logic  fault_i,
    output logic  locked_o,
    output logic  fail_o,
    output rate_e rate_o
);
    localparam int AG_W = $clog2(ACQ_N + 1);

    logic [AG_W-1:0] agree;
    rate_e           last;

    // Lock state machine with agreement counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b0;
            fail_o   <= 1'b0;
            rate_o   <= RATE_8K;
            agree    <= '0;
            last     <= RATE_8K;
        end else if (locked_o) begin
            if (fault_i) begin
                locked_o <= 1'b0;
                fail_o   <= 1'b1;
                agree    <= '0;
            end
        end else if (edge_i) begin
            last <= cand_i;
            if (!cand_ok_i) begin
                agree <= '0;
            end else if (agree != '0 && cand_i == last) begin
                if (agree == AG_W'(ACQ_N - 1)) begin
                    locked_o <= 1'b1;
                    fail_o   <= 1'b0;
                    rate_o   <= cand_i;
                    agree    <= '0;
                end else begin
                    agree <= agree + AG_W'(1);
                end
            end else begin
                agree <= AG_W'(1);
            end
        end
    end
endmodule

// File: rtl/ref_rate_monitor.sv
// Reference rate detector and monitor top. Samples ref_in on clk,
// classifies the rate, and flags failures from two checkers.
// Assumes SAMPLE_MHZ resolves the shortest 19.44 MHz period.
module ref_rate_monitor
    import refmon_pkg::*;
#(
    parameter int SAMPLE_MHZ     = 200,
    parameter int ACQ_PERIODS    = 4,
    parameter int COARSE_NS      = 30000,
    parameter int COARSE_TOL_PCT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    output logic [1:0] rate_code,
    output logic       rate_valid,
    output logic       ref_fail
);
    localparam int WIN_TICKS = COARSE_NS * SAMPLE_MHZ / 1000;
    localparam int CNT_W     = $clog2(per_max_ticks(0, SAMPLE_MHZ) + 2) + 1;

    logic             ref_edge;
    logic [CNT_W-1:0] since;
    rate_e            cand, rate;
    logic             cand_ok, locked, fail;
    logic             sc_fault, cf_fault;

    refmon_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_in), .edge_o(ref_edge)
    );

    refmon_period #(.SAMPLE_MHZ(SAMPLE_MHZ), .CNT_W(CNT_W)) u_period (
        .clk(clk), .rst_n(rst_n), .edge_i(ref_edge),
        .since_o(since), .cand_o(cand), .cand_ok_o(cand_ok)
    );

    refmon_cycle_check #(.SAMPLE_MHZ(SAMPLE_MHZ), .CNT_W(CNT_W)) u_cyc (
        .active_i(locked), .edge_i(ref_edge), .since_i(since),
        .rate_i(rate), .fault_o(sc_fault)
    );

    refmon_freq_check #(
        .SAMPLE_MHZ(SAMPLE_MHZ), .WIN_TICKS(WIN_TICKS), .TOL_PCT(COARSE_TOL_PCT)
    ) u_freq (
        .clk(clk), .rst_n(rst_n), .active_i(locked), .edge_i(ref_edge),
        .rate_i(rate), .fault_o(cf_fault)
    );

    refmon_acq #(.ACQ_N(ACQ_PERIODS)) u_acq (
        .clk(clk), .rst_n(rst_n), .edge_i(ref_edge), .cand_i(cand),
        .cand_ok_i(cand_ok), .fault_i(sc_fault | cf_fault),
        .locked_o(locked), .fail_o(fail), .rate_o(rate)
    );

    assign rate_code  = rate;
    assign rate_valid = locked;
    assign ref_fail   = fail;
endmodule

// File: rtl/ref_rate_monitor_chk.sv
// Property checker for ref_rate_monitor, attached by bind below.
// Keeps its own gap counter from the detected edge pulse.
module ref_rate_monitor_chk
    import refmon_pkg::*;
#(
    parameter int SAMPLE_MHZ = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_edge,
    input logic [1:0] rate_code,
    input logic       rate_valid,
    input logic       ref_fail
);
    localparam int GAP_SAT = 1 << 30;
    int gap, lim_hi, lim_lo;

    // Cycles since last detected edge
    always_ff @(posedge clk) begin
        if (!rst_n)            gap <= GAP_SAT;
        else if (ref_edge)     gap <= 1;
        else if (gap < GAP_SAT) gap <= gap + 1;
    end

    always_comb begin
        lim_hi = per_max_ticks(int'(rate_code), SAMPLE_MHZ);
        lim_lo = per_min_ticks(int'(rate_code), SAMPLE_MHZ);
    end

    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!rate_valid && !ref_fail && rate_code == 2'd0));

    a_r2_lock_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_valid) |-> $past(ref_edge));

    a_r6_fail_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fail |-> !rate_valid);

    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fail |=> (ref_fail || rate_valid));

    a_r7_rate_changes_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rate_code) |-> $rose(rate_valid));

    a_r4_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rate_valid |-> (gap <= lim_hi + 1));

    a_r3_short_period: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_valid && ref_edge && gap < lim_lo) |=> !rate_valid);
endmodule

bind ref_rate_monitor ref_rate_monitor_chk #(.SAMPLE_MHZ(SAMPLE_MHZ)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .rate_code(rate_code),
    .rate_valid(rate_valid), .ref_fail(ref_fail)
);

// File: tb/test_ref_rate_monitor.sv
// Bench for ref_rate_monitor at a 50 MHz sampling clock, with a
// behavioural model compared on every clock plus phase checks.
module test_ref_rate_monitor;
    localparam int MHZ = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic [1:0] rate_code;
    logic       rate_valid, ref_fail;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ref_rate_monitor #(.SAMPLE_MHZ(MHZ)) i_ref_rate_monitor (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .rate_code(rate_code), .rate_valid(rate_valid), .ref_fail(ref_fail)
    );

    // Limits at 50 MHz worked out from the requirements
    int pmin [4] = '{6050, 13, 3, 1};
    int pmax [4] = '{6401, 37, 10, 5};
    int clo  [4] = '{0, 54, 220, 523};
    int chi  [4] = '{2, 69, 272, 643};
    localparam int WIN = 1500;
    localparam int SAT = 16383;

    function automatic int classify(input int p);
        if (p >= 1250) return 0;
        if (p >= 15)   return 1;
        if (p >= 4)    return 2;
        return 3;
    endfunction

    // Behavioural model
    bit m_hist [$];
    int m_since, m_agree, m_last, m_rate, m_win, m_ecnt;
    bit m_locked, m_fail;

    always @(posedge clk) begin
        bit e, flt, ok;
        int p, c, tot;
        if (!rst_n) begin
            m_hist = '{0, 0, 0};
            m_since = SAT; m_agree = 0; m_last = 0; m_rate = 0;
            m_win = 0; m_ecnt = 0; m_locked = 0; m_fail = 0;
        end else begin
            e = m_hist[1] && !m_hist[2];
            p = m_since;
            if (m_locked) begin
                flt = e ? (p < pmin[m_rate] || p > pmax[m_rate]) : (p > pmax[m_rate]);
                if (m_win == WIN - 1) begin
                    tot = m_ecnt + int'(e);
                    if (tot < clo[m_rate] || tot > chi[m_rate]) flt = 1;
                    m_win = 0; m_ecnt = 0;
                end else begin
                    m_win++; m_ecnt += int'(e);
                end
                if (flt) begin m_locked = 0; m_fail = 1; m_agree = 0; end
            end else begin
                m_win = 0; m_ecnt = 0;
                if (e) begin
                    c = classify(p);
                    ok = (p >= pmin[c]) && (p <= pmax[c]);
                    if (!ok) m_agree = 0;
                    else if (m_agree != 0 && c == m_last) begin
                        if (m_agree == 3) begin
                            m_locked = 1; m_fail = 0; m_rate = c; m_agree = 0;
                        end else m_agree++;
                    end else m_agree = 1;
                    m_last = c;
                end
            end
            if (e) m_since = 1;
            else if (m_since != SAT) m_since++;
            m_hist.push_front(ref_in);
            void'(m_hist.pop_back());
        end
    end

    // Per-clock comparison and event monitors
    bit saw_fail, saw_valid;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks += 3;
            if (rate_valid !== m_locked) begin
                errors++;
                $display("FAIL R2 rate_valid act=%0b exp=%0b t=%0t", rate_valid, m_locked, $time);
            end
            if (ref_fail !== m_fail) begin
                errors++;
                $display("FAIL R6 ref_fail act=%0b exp=%0b t=%0t", ref_fail, m_fail, $time);
            end
            if (int'(rate_code) !== m_rate) begin
                errors++;
                $display("FAIL R7 rate_code act=%0d exp=%0d t=%0t", rate_code, m_rate, $time);
            end
            if (ref_fail) saw_fail = 1;
            if (rate_valid) saw_valid = 1;
        end
    end

    task automatic chk(input bit cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_per(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            ref_in = 1'b1;
            repeat (p / 2) @(negedge clk);
            ref_in = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    endtask

    task automatic mark();
        saw_fail = 0;
        saw_valid = 0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rate_valid && !ref_fail && rate_code == 0, "R9 reset outputs",
            {rate_code, rate_valid, ref_fail}, 0);

        // 2.048 MHz at 24 cycles
        run_per(24, 200);
        chk(rate_valid && rate_code == 1, "R1 2.048 MHz lock", rate_code, 1);
        chk(!ref_fail, "R5 nominal 2.048 MHz passes coarse", ref_fail, 0);

        // Switch to 19.44 MHz: short period fault, then relock
        mark();
        run_per(2, 1);
        run_per(3, 1);
        run_per(2, 1);
        chk(saw_fail, "R3 short period flags failure", saw_fail, 1);
        for (int i = 0; i < 1500; i++) begin
            run_per(2, 1);
            run_per(3, 1);
        end
        chk(rate_valid && rate_code == 3, "R1 19.44 MHz lock", rate_code, 3);

        // Loss of edges
        mark();
        repeat (100) @(negedge clk);
        chk(saw_fail && ref_fail && !rate_valid, "R4 missing edges flag", ref_fail, 1);
        chk(rate_code == 3, "R7 rate held after loss", rate_code, 3);

        // 8.192 MHz, then a coarse-only offset
        run_per(6, 1000);
        chk(rate_valid && rate_code == 2, "R2 8.192 MHz lock", rate_code, 2);
        mark();
        run_per(7, 700);
        chk(saw_fail, "R5 coarse count low flags", saw_fail, 1);
        run_per(6, 600);
        chk(rate_valid && !ref_fail, "R6 fail cleared by relock", ref_fail, 0);

        // 8 kHz, then one short period
        run_per(6250, 7);
        chk(rate_valid && rate_code == 0, "R1 8 kHz lock", rate_code, 0);
        mark();
        run_per(6000, 1);
        run_per(6250, 1);
        chk(saw_fail && !rate_valid, "R3 8 kHz short period", saw_fail, 1);

        // Out-of-window periods never qualify
        run_per(45, 3);
        mark();
        run_per(45, 100);
        chk(!saw_valid, "R8 out-of-window periods ignored", saw_valid, 0);
        chk(rate_code == 0, "R7 rate held while unqualified", rate_code, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - errors, checks);
            $finish;
        end
    end
endmodule